// File: doc/BRIEF.md
# Tick Prescaler and Input Glitch Filter

This block sits in front of a timer's counting stage and turns one of several clock sources into something that stage can count. Each source arrives as a one-cycle strobe in the system clock domain, so the block never gates or derives a clock. A 2-bit select chooses the source strobe that advances the internal counters.

In divide mode the block emits a one-cycle `tick` once every 2^(N+1) selected strobes, where N is a 4-bit scale setting. In filter mode the same counter qualifies an asynchronous pulse input. The input is first synchronised. A new level is accepted on `filt_level` only after it has differed from the accepted level for 2^N selected strobes in a row. If the input falls back before that, the count starts over. The filter has no setting for N = 0, and the level is then frozen. A bypass input skips both functions. In divide mode every selected strobe becomes a tick. In filter mode the synchronised input drives `filt_level` directly.

Changing any configuration input restarts the counters. Dropping the enable also restarts them and returns both outputs to 0.

Top module: `tick_prescaler`

## Requirements
- R1: Only the strobe on `src_strobe[src_sel]` advances the divider or filter; strobes on the other three bits are ignored.
- R2: With `enable`=1, `mode`=0 and `bypass`=0, `tick` is high for exactly one cycle, the cycle after every 2^(N+1)-th selected strobe (N = `scale`, 0..15, giving 2..65536).
- R3: With `mode`=0 and `bypass`=1, `tick` is high in the cycle after each selected strobe.
- R4: With `mode`=1, `bypass`=0 and N ≥ 1, `filt_level` takes the synchronised input value in the cycle after the 2^N-th selected strobe seen while that value differed from `filt_level` (2..32768 strobes).
- R5: If the synchronised input returns to `filt_level` before the filter count completes, the count is cleared and nothing is passed on.
- R6: With `mode`=1, `bypass`=0 and N = 0, `filt_level` does not change.
- R7: With `mode`=1 and `bypass`=1, `filt_level` follows `pulse_in` with three cycles of latency (two synchroniser stages plus one register).
- R8: A change on `mode`, `bypass`, `scale` or `src_sel` clears the divider and filter counts, and the strobe in that cycle is not counted.
- R9: While `enable` is 0, the counts are held at zero, and `tick` and `filt_level` are 0 from the next cycle on.
- R10: In filter mode (`mode`=1), `tick` stays 0.
- R11: After reset, `tick` and `filt_level` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; 0 clears the counts and outputs |
| mode | input | 1 | 0 = divide, 1 = glitch filter |
| bypass | input | 1 | 1 = skip the divider or filter |
| scale | input | 4 | Scale N: divide by 2^(N+1), or filter 2^N strobes |
| src_sel | input | 2 | Index of the source strobe used |
| src_strobe | input | 4 | One-cycle strobes of the four clock sources |
| pulse_in | input | 1 | Asynchronous input to be filtered |
| tick | output | 1 | One-cycle count tick (divide mode) |
| filt_level | output | 1 | Filtered input level (filter mode) |

## Verification
The hardest situation to reach is a filter count that has been partly advanced and is then abandoned, because the input falls back to the accepted level. A wrong design that forgets to clear the count looks correct in every plain edge test. The stimulus raises the input, gives one strobe fewer than needed, and lowers the input again. It then raises the input once more and shows that a full 2^N strobes are needed again. The largest scale setting is also driven, with strobes held high on every cycle, to check the 16-bit terminal counts in both modes.

// File: rtl/prescale_pkg.sv
package prescale_pkg;

    typedef enum logic {
        MODE_DIVIDE = 1'b0,
        MODE_FILTER = 1'b1
    } pre_mode_e;

endpackage

// File: rtl/prescale_sync.sv
module prescale_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/prescale_src_select.sv
module prescale_src_select #(
    parameter int NSRC  = 4,
    parameter int SEL_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  src_strobe,
    input  logic [SEL_W-1:0] src_sel,
    output logic             sel_strobe
);
    logic [NSRC-1:0] hit;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign hit[i] = src_strobe[i] && (src_sel == SEL_W'(i));
    end

    assign sel_strobe = |hit;
endmodule

// File: rtl/prescale_core.sv
module prescale_core
    import prescale_pkg::*;
#(
    parameter int SCALE_W = 4,
    parameter int SEL_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  pre_mode_e          mode,
    input  logic               bypass,
    input  logic [SCALE_W-1:0] scale,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic               strobe,
    input  logic               din,
    output logic               tick,
    output logic               level
);
    localparam int CNT_W = 1 << SCALE_W;
    localparam int CFG_W = 2 + SCALE_W + SEL_W;
    localparam logic [CNT_W-1:0] ONES = '1;

    typedef struct packed {
        logic [CNT_W-1:0] div_cnt;
        logic [CNT_W-1:0] flt_cnt;
        logic             tick;
        logic             level;
        logic [CFG_W-1:0] cfg;
    } core_state_t;

    core_state_t st_d, st_q;
    logic [CFG_W-1:0] cfg_now;
    logic [CNT_W-1:0] div_last, flt_last;
    logic             cfg_changed;

    always_comb begin
        cfg_now     = {mode, bypass, scale, src_sel};
        cfg_changed = (cfg_now != st_q.cfg);
        div_last    = ONES >> (CNT_W - 1 - int'(scale));
        flt_last    = ONES >> (CNT_W - int'(scale));

        st_d      = st_q;
        st_d.tick = 1'b0;
        st_d.cfg  = cfg_now;

        if (!enable) begin
            st_d.div_cnt = '0;
            st_d.flt_cnt = '0;
            st_d.level   = 1'b0;
        end else if (cfg_changed) begin
            st_d.div_cnt = '0;
            st_d.flt_cnt = '0;
        end else if (mode == MODE_DIVIDE) begin
            st_d.flt_cnt = '0;
            if (strobe) begin
                if (bypass) begin
                    st_d.tick = 1'b1;
                end else if (st_q.div_cnt == div_last) begin
                    st_d.tick    = 1'b1;
                    st_d.div_cnt = '0;
                end else begin
                    st_d.div_cnt = st_q.div_cnt + 1'b1;
                end
            end
        end else begin
            st_d.div_cnt = '0;
            if (bypass) begin
                st_d.level   = din;
                st_d.flt_cnt = '0;
            end else if (din == st_q.level || scale == '0) begin
                st_d.flt_cnt = '0;
            end else if (strobe) begin
                if (st_q.flt_cnt == flt_last) begin
                    st_d.level   = din;
                    st_d.flt_cnt = '0;
                end else begin
                    st_d.flt_cnt = st_q.flt_cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick  = st_q.tick;
    assign level = st_q.level;
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler
    import prescale_pkg::*;
#(
    parameter int SCALE_W     = 4,
    parameter int NSRC        = 4,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = $clog2(NSRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               mode,
    input  logic               bypass,
    input  logic [SCALE_W-1:0] scale,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic [NSRC-1:0]    src_strobe,
    input  logic               pulse_in,
    output logic               tick,
    output logic               filt_level
);
    logic sel_strobe;
    logic pin_sync;

    prescale_src_select #(.NSRC(NSRC), .SEL_W(SEL_W)) u_sel (
        .src_strobe (src_strobe),
        .src_sel    (src_sel),
        .sel_strobe (sel_strobe)
    );

    prescale_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pulse_in),
        .dout  (pin_sync)
    );

    prescale_core #(.SCALE_W(SCALE_W), .SEL_W(SEL_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .mode    (pre_mode_e'(mode)),
        .bypass  (bypass),
        .scale   (scale),
        .src_sel (src_sel),
        .strobe  (sel_strobe),
        .din     (pin_sync),
        .tick    (tick),
        .level   (filt_level)
    );
endmodule

// File: rtl/prescale_checker.sv
module prescale_checker #(
    parameter int SCALE_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               enable,
    input logic               mode,
    input logic               bypass,
    input logic [SCALE_W-1:0] scale,
    input logic               sel_strobe,
    input logic               tick,
    input logic               filt_level
);
    p_tick_spaced_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !mode && !bypass && tick) |=> !tick);

    p_tick_from_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(sel_strobe));

    p_filter_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && mode) |=> !tick);

    p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!tick && !filt_level));

    p_scale0_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && mode && !bypass && scale == '0) |=> $stable(filt_level));

    p_level_needs_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && mode && !bypass && !sel_strobe) |=> $stable(filt_level));
endmodule

bind tick_prescaler prescale_checker #(.SCALE_W(SCALE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .mode       (mode),
    .bypass     (bypass),
    .scale      (scale),
    .sel_strobe (sel_strobe),
    .tick       (tick),
    .filt_level (filt_level)
);

// File: tb/tick_prescaler_test.sv
`timescale 1ns/1ps
module tick_prescaler_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       mode = 1'b0;
    logic       bypass = 1'b0;
    logic [3:0] scale = 4'd0;
    logic [1:0] src_sel = 2'd0;
    logic [3:0] src_strobe = 4'd0;
    logic       pulse_in = 1'b0;
    logic       tick;
    logic       filt_level;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    tick_prescaler uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
        .bypass(bypass), .scale(scale), .src_sel(src_sel),
        .src_strobe(src_strobe), .pulse_in(pulse_in),
        .tick(tick), .filt_level(filt_level)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic setup(input logic en, input logic md, input logic bp,
                         input logic [3:0] n, input logic [1:0] sel);
        @(negedge clk);
        enable = en; mode = md; bypass = bp; scale = n; src_sel = sel;
        repeat (2) @(negedge clk);
    endtask

    // hold strobe idx high for cnt consecutive cycles; returns at a negedge
    task automatic strobes(input int idx, input int cnt);
        @(negedge clk);
        src_strobe[idx] = 1'b1;
        repeat (cnt) @(negedge clk);
        src_strobe = '0;
    endtask

    task automatic set_pin(input logic v);
        @(negedge clk);
        pulse_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R11 tick", tick, 1'b0);
        chk("R11 level", filt_level, 1'b0);
    endtask

    task automatic t_divide;
        setup(1, 0, 0, 4'd0, 2'd0);
        strobes(0, 1); chk("R2 n0 s1", tick, 1'b0);
        strobes(0, 1); chk("R2 n0 s2", tick, 1'b1);
        @(negedge clk); chk("R2 one cycle", tick, 1'b0);
        strobes(0, 1); chk("R2 n0 s3", tick, 1'b0);
        strobes(0, 1); chk("R2 n0 s4", tick, 1'b1);
        setup(1, 0, 0, 4'd3, 2'd0);
        strobes(0, 15); chk("R2 n3 15", tick, 1'b0);
        strobes(0, 1);  chk("R2 n3 16", tick, 1'b1);
    endtask

    task automatic t_select;
        setup(1, 0, 0, 4'd1, 2'd2);
        strobes(0, 8); strobes(1, 8); strobes(3, 8);
        chk("R1 others ignored", tick, 1'b0);
        strobes(2, 3); chk("R1 sel 3 of 4", tick, 1'b0);
        strobes(2, 1); chk("R1 sel 4 of 4", tick, 1'b1);
    endtask

    task automatic t_div_bypass;
        setup(1, 0, 1, 4'd5, 2'd1);
        strobes(1, 1); chk("R3 each strobe", tick, 1'b1);
        @(negedge clk); chk("R3 pulse ends", tick, 1'b0);
        strobes(1, 1); chk("R3 again", tick, 1'b1);
    endtask

    task automatic t_cfg_change;
        setup(1, 0, 0, 4'd1, 2'd0);
        strobes(0, 3);
        setup(1, 0, 0, 4'd2, 2'd0);
        strobes(0, 5); chk("R8 count restarted", tick, 1'b0);
        strobes(0, 3); chk("R8 full ratio", tick, 1'b1);
    endtask

    task automatic t_disable;
        setup(1, 0, 0, 4'd1, 2'd0);
        strobes(0, 3);
        setup(0, 0, 0, 4'd1, 2'd0);
        chk("R9 tick off", tick, 1'b0);
        setup(1, 0, 0, 4'd1, 2'd0);
        strobes(0, 1); chk("R9 count cleared", tick, 1'b0);
        strobes(0, 3); chk("R9 full ratio", tick, 1'b1);
    endtask

    task automatic t_filter;
        setup(1, 1, 0, 4'd2, 2'd3);
        set_pin(1'b1);
        strobes(3, 3); chk("R4 rise 3 of 4", filt_level, 1'b0);
        chk("R10 no tick", tick, 1'b0);
        strobes(3, 1); chk("R4 rise 4 of 4", filt_level, 1'b1);
        set_pin(1'b0);
        strobes(3, 3); chk("R4 fall 3 of 4", filt_level, 1'b1);
        strobes(3, 1); chk("R4 fall 4 of 4", filt_level, 1'b0);
        chk("R10 no tick after", tick, 1'b0);
    endtask

    task automatic t_restart;
        setup(1, 1, 0, 4'd2, 2'd0);
        set_pin(1'b1);
        strobes(0, 3);
        set_pin(1'b0);
        chk("R5 glitch rejected", filt_level, 1'b0);
        set_pin(1'b1);
        strobes(0, 3); chk("R5 count restarted", filt_level, 1'b0);
        strobes(0, 1); chk("R5 full length", filt_level, 1'b1);
        setup(0, 1, 0, 4'd2, 2'd0);
        chk("R9 level cleared", filt_level, 1'b0);
    endtask

    task automatic t_scale0;
        setup(1, 1, 0, 4'd0, 2'd0);
        set_pin(1'b0);
        set_pin(1'b1);
        strobes(0, 20); chk("R6 level frozen", filt_level, 1'b0);
    endtask

    task automatic t_fbypass;
        set_pin(1'b0);
        setup(1, 1, 1, 4'd4, 2'd0);
        chk("R7 start low", filt_level, 1'b0);
        @(negedge clk); pulse_in = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7 not before 3", filt_level, 1'b0);
        @(negedge clk);
        chk("R7 at 3 cycles", filt_level, 1'b1);
    endtask

    task automatic t_long;
        setup(1, 0, 0, 4'd15, 2'd0);
        strobes(0, 65535); chk("R2 n15 65535", tick, 1'b0);
        strobes(0, 1);     chk("R2 n15 65536", tick, 1'b1);
        setup(1, 1, 0, 4'd15, 2'd1);
        set_pin(1'b0);
        strobes(1, 32767); chk("R4 n15 32767", filt_level, 1'b1);
        strobes(1, 1);     chk("R4 n15 32768", filt_level, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_divide();
        t_select();
        t_div_bypass();
        t_cfg_change();
        t_disable();
        t_filter();
        t_restart();
        t_scale0();
        t_fbypass();
        t_long();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule